// File: doc/BRIEF.md
# Triggered Circular Waveform Capture Controller

This controller writes a stream of 32-bit sample words into a ring of memory locations that covers the upper half of a 4096-word address space. The ring starts at 0x800 and ends at 0xFFF. On each sample strobe it produces one write, with the address, the data and a write enable. It tracks which 128-word page of the ring was completed last. When the ring wraps it raises a page-full flag.

Two trigger modes decide when the filling stops. In the first, the first enabled event freezes the ring straight away, so the memory holds the history that led up to the event. In the second, filling goes on for exactly 1024 more locations, so the stored record is centred on the event. Either way the block latches the address of the last sample written when the trigger was taken. Capture is armed by a rising edge of the enable input. Dropping the enable clears the page index, the latched address and the flags, but the stored samples are left as they are.

Top module: `wfb_capture_ctrl`

## Requirements
- R1: While capture is running, each cycle with `smp_valid` high makes exactly one write with `mem_wdata` equal to `smp_data`. The first write after a start goes to 0x800, each later write goes to the next address, and 0xFFF is followed by 0x800.
- R2: Triggers act only when `cap_sel` is 1 and `mode` is 1 (stop) or 2 (centre). With any other setting the ring fills without end, and events change neither `trig_seen` nor `trig_addr`.
- R3: A trigger qualifies when any bit of `evt & trig_mask` is 1. Event bits: 0 dip, 1 swell, 2 overcurrent, 3..5 current zero crossings, 6..8 voltage zero crossings, 9 combined zero crossing. Mask bit 10 alone forces a trigger. Only the first trigger after a start is latched, and later events leave `trig_addr` unchanged.
- R4: In stop mode, a write in the trigger cycle still takes place and no write follows it. `trig_addr` becomes the address of the last write made since the start, or 0xFFF if there was none. In the next cycle `trig_seen` and `cap_stopped` read 1.
- R5: In centre mode, `trig_seen` is set at the trigger and exactly 1024 further writes follow. The last of them goes to `trig_addr`+1024 taken around the ring, and then `cap_stopped` is set and writing ends.
- R6: While `cap_en` is 0 there are no writes. From the next cycle on, `trig_addr`, `last_page`, `trig_seen`, `cap_stopped` and `page_full` read 0.
- R7: A write to the final word of a page (ring offset modulo 128 equal to 127) sets `last_page` to that page's number, 0..15. A write to 0xFFF sets `page_full`.
- R8: Once capture has stopped, writing resumes only after `cap_en` goes to 0 and back to 1. If mask bit 10 is still set at re-enable, the trigger is taken in the first running cycle.
- R9: `flag_clr` bit 0 clears `trig_seen`, bit 1 clears `cap_stopped` and bit 2 clears `page_full`, one cycle later. A set in the same cycle wins over the clear.
- R10: After reset, all outputs read 0 and no write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable; its rising edge starts a fill |
| cap_sel | input | 1 | Selects triggered capture |
| mode | input | 2 | 1 stop on trigger, 2 centre on trigger |
| trig_mask | input | 11 | Trigger enable mask; bit 10 forces a trigger |
| evt | input | 11 | Event pulses |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Sample word |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| trig_seen | output | 1 | Sticky: trigger taken |
| cap_stopped | output | 1 | Sticky: filling has ended |
| trig_addr | output | 12 | Address latched at the trigger |
| last_page | output | 4 | Index of the last completed page |
| page_full | output | 1 | Sticky: the final page of the ring completed |

## Verification
The hardest case to reach is the end of a centre capture when the trigger lands late in the ring. The 1024 post-trigger writes must then cross the 0xFFF to 0x800 wrap and stop on exactly the right word, even though sample strobes arrive with gaps. The stimulus first writes several hundred samples with an irregular strobe pattern. It fires the trigger in a cycle with no strobe and keeps the gaps going until the stop. The final write address is then checked against the latched address plus 1024 around the ring. A second hard case is a force bit left set across a re-enable. The bench reaches it by stopping a capture and toggling the enable while the force bit stays set. It then checks that the trigger is taken in the first running cycle.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
  // flag_clr bit positions
  localparam int unsigned FLG_SEEN = 0;
  localparam int unsigned FLG_STOP = 1;
  localparam int unsigned FLG_FULL = 2;
  localparam int unsigned FLG_N    = 3;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_STOP   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_RSVD   = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/wfb_wptr.sv
module wfb_wptr #(
  parameter int unsigned RING_AW = 11,
  parameter int unsigned PAGE_AW = 7,
  localparam int unsigned AW   = RING_AW + 1,
  localparam int unsigned PG_W = RING_AW - PAGE_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dis,
  input  logic            wr,
  input  logic            pf_clr,
  output logic [AW-1:0]   addr,
  output logic [AW-1:0]   last_addr,
  output logic [PG_W-1:0] last_page,
  output logic            page_full
);
  logic [RING_AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0]      last_q, last_d;
  logic [PG_W-1:0]    lp_q, lp_d;
  logic               pf_q, pf_d;

  assign addr      = {1'b1, ptr_q};
  assign last_addr = last_q;
  assign last_page = lp_q;
  assign page_full = pf_q;

  always_comb begin
    ptr_d  = ptr_q;
    last_d = last_q;
    lp_d   = lp_q;
    pf_d   = pf_q;
    if (start) begin
      ptr_d  = '0;
      last_d = '1;
    end else if (wr) begin
      ptr_d  = ptr_q + 1'b1;
      last_d = addr;
      if (&ptr_q[PAGE_AW-1:0]) lp_d = ptr_q[RING_AW-1:PAGE_AW];
    end
    if (wr && (&ptr_q)) pf_d = 1'b1;
    else if (pf_clr)    pf_d = 1'b0;
    if (dis) begin
      lp_d = '0;
      pf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      last_q <= '0;
      lp_q   <= '0;
      pf_q   <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      last_q <= last_d;
      lp_q   <= lp_d;
      pf_q   <= pf_d;
    end
  end
endmodule

// File: rtl/wfb_trig.sv
module wfb_trig #(
  parameter int unsigned NSRC    = 11,
  parameter int unsigned AW      = 12,
  parameter int unsigned POST    = 1024,
  localparam int unsigned CNT_W  = $clog2(POST) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dis,
  input  logic            wr,
  input  logic            run,
  input  logic            sel_stop,
  input  logic            sel_ctr,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] mask,
  input  logic [AW-1:0]   cur_addr,
  input  logic [AW-1:0]   last_addr,
  input  logic            seen_clr,
  input  logic            stop_clr,
  output logic            seen,
  output logic            stopped,
  output logic [AW-1:0]   taddr,
  output logic            halt
);
  logic             trg_q, trg_d;
  logic             ctr_q, ctr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             stop_q, stop_d;
  logic [AW-1:0]    ta_q, ta_d;
  logic             qual, hit, fin;

  assign qual = (|(evt & mask)) | mask[NSRC-1];
  assign hit  = run & ~trg_q & (sel_stop | sel_ctr) & qual;
  assign fin  = run & trg_q & ctr_q & wr & (cnt_q == CNT_W'(1));
  assign halt = (hit & sel_stop) | fin;

  assign seen    = seen_q;
  assign stopped = stop_q;
  assign taddr   = ta_q;

  always_comb begin
    trg_d  = trg_q;
    ctr_d  = ctr_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;
    stop_d = stop_q;
    ta_d   = ta_q;
    if (hit) begin
      trg_d  = 1'b1;
      ctr_d  = sel_ctr;
      cnt_d  = CNT_W'(POST);
      seen_d = 1'b1;
      ta_d   = wr ? cur_addr : last_addr;
    end else begin
      if (trg_q && ctr_q && wr) cnt_d = cnt_q - 1'b1;
      if (seen_clr) seen_d = 1'b0;
    end
    if (halt)          stop_d = 1'b1;
    else if (stop_clr) stop_d = 1'b0;
    if (start) begin
      trg_d = 1'b0;
      ctr_d = 1'b0;
    end
    if (dis) begin
      trg_d  = 1'b0;
      ctr_d  = 1'b0;
      cnt_d  = '0;
      seen_d = 1'b0;
      stop_d = 1'b0;
      ta_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_q  <= 1'b0;
      ctr_q  <= 1'b0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
      stop_q <= 1'b0;
      ta_q   <= '0;
    end else begin
      trg_q  <= trg_d;
      ctr_q  <= ctr_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      stop_q <= stop_d;
      ta_q   <= ta_d;
    end
  end
endmodule

// File: rtl/wfb_capture_ctrl.sv
module wfb_capture_ctrl
  import wfb_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NSRC    = 11,
  parameter int unsigned RING_AW = 11,
  parameter int unsigned PAGE_AW = 7,
  parameter int unsigned POST    = 1024,
  localparam int unsigned AW     = RING_AW + 1,
  localparam int unsigned PG_W   = RING_AW - PAGE_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             cap_sel,
  input  logic [1:0]       mode,
  input  logic [NSRC-1:0]  trig_mask,
  input  logic [NSRC-1:0]  evt,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_data,
  input  logic [FLG_N-1:0] flag_clr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             trig_seen,
  output logic             cap_stopped,
  output logic [AW-1:0]    trig_addr,
  output logic [PG_W-1:0]  last_page,
  output logic             page_full
);
  logic          en_q, run_q, run_d;
  logic          start, dis, wr, run, halt;
  logic          sel_stop, sel_ctr;
  logic [AW-1:0] cur_addr, last_addr;

  assign start    = cap_en & ~en_q;
  assign dis      = ~cap_en;
  assign run      = run_q & cap_en;
  assign wr       = run & smp_valid;
  assign sel_stop = cap_sel & (cap_mode_e'(mode) == MODE_STOP);
  assign sel_ctr  = cap_sel & (cap_mode_e'(mode) == MODE_CENTER);

  always_comb begin
    run_d = run_q;
    if (dis)        run_d = 1'b0;
    else if (start) run_d = 1'b1;
    else if (halt)  run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      en_q  <= cap_en;
      run_q <= run_d;
    end
  end

  wfb_wptr #(.RING_AW(RING_AW), .PAGE_AW(PAGE_AW)) u_wptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dis       (dis),
    .wr        (wr),
    .pf_clr    (flag_clr[FLG_FULL]),
    .addr      (cur_addr),
    .last_addr (last_addr),
    .last_page (last_page),
    .page_full (page_full)
  );

  wfb_trig #(.NSRC(NSRC), .AW(AW), .POST(POST)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dis       (dis),
    .wr        (wr),
    .run       (run),
    .sel_stop  (sel_stop),
    .sel_ctr   (sel_ctr),
    .evt       (evt),
    .mask      (trig_mask),
    .cur_addr  (cur_addr),
    .last_addr (last_addr),
    .seen_clr  (flag_clr[FLG_SEEN]),
    .stop_clr  (flag_clr[FLG_STOP]),
    .seen      (trig_seen),
    .stopped   (cap_stopped),
    .taddr     (trig_addr),
    .halt      (halt)
  );

  assign mem_we    = wr;
  assign mem_addr  = cur_addr;
  assign mem_wdata = smp_data;
endmodule

// File: rtl/wfb_capture_ctrl_chk.sv
module wfb_capture_ctrl_chk #(
  parameter int unsigned AW   = 12,
  parameter int unsigned PG_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          trig_seen,
  input logic          cap_stopped,
  input logic [AW-1:0] trig_addr,
  input logic [PG_W-1:0] last_page,
  input logic          page_full
);
  logic [AW-1:0] prev_q;
  logic          hv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      hv_q   <= 1'b0;
    end else begin
      if (!cap_en)     hv_q <= 1'b0;
      else if (mem_we) hv_q <= 1'b1;
      if (mem_we) prev_q <= mem_addr;
    end
  end

  // R1: consecutive writes step around the upper-half ring
  a_r1_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && hv_q) |-> (mem_addr == {1'b1, prev_q[AW-2:0] + 1'b1}));

  // R4, R5: no write once filling has ended
  a_r4_no_write_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stopped |-> !mem_we);

  // R6: disabling clears the latched address and the page index
  a_r6_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (trig_addr == '0 && last_page == '0));

  // R3: a trigger is taken only while enabled
  a_r3_seen_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_seen) |-> $past(cap_en));

  // R7: page_full rises only after a write to the ring's final word
  a_r7_full_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_full) |-> $past(mem_we && (&mem_addr)));
endmodule

bind wfb_capture_ctrl wfb_capture_ctrl_chk #(.AW(AW), .PG_W(PG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_en      (cap_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .trig_seen   (trig_seen),
  .cap_stopped (cap_stopped),
  .trig_addr   (trig_addr),
  .last_page   (last_page),
  .page_full   (page_full)
);

// File: tb/tb_wfb_capture_ctrl.sv
`timescale 1ns/1ps
module tb_wfb_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic        cap_sel = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [10:0] trig_mask = '0;
  logic [10:0] evt = '0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic [2:0]  flag_clr = '0;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        trig_seen, cap_stopped, page_full;
  logic [11:0] trig_addr;
  logic [3:0]  last_page;

  always #10 clk = ~clk;

  wfb_capture_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_sel(cap_sel), .mode(mode),
    .trig_mask(trig_mask), .evt(evt), .smp_valid(smp_valid), .smp_data(smp_data),
    .flag_clr(flag_clr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .trig_seen(trig_seen), .cap_stopped(cap_stopped), .trig_addr(trig_addr),
    .last_page(last_page), .page_full(page_full)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int m_en = 0, m_run = 0, m_ptr = 0, m_last = 0, m_lp = 0, m_pf = 0;
  int m_ts = 0, m_cs = 0, m_ta = 0, m_trg = 0, m_ctr = 0, m_cnt = 0;
  int nwr = 0, last_wa = 0;
  int writes_q[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // sample, compare, advance model and clock by one cycle
  task automatic tick();
    int we, addr, qual, ts, tc, hit, fin, start;
    int n_run, n_ptr, n_last, n_lp, n_pf, n_ts, n_cs, n_ta, n_trg, n_ctr, n_cnt;
    #1;
    we   = (m_run != 0 && cap_en && smp_valid) ? 1 : 0;
    addr = 2048 + m_ptr;
    chk("R1 mem_we", int'(mem_we), we);
    if (we != 0) begin
      chk("R1 mem_addr", int'(mem_addr), addr);
      chk("R1 mem_wdata", int'(mem_wdata), int'(smp_data));
    end
    chk("R3 trig_seen", int'(trig_seen), m_ts);
    chk("R5 cap_stopped", int'(cap_stopped), m_cs);
    chk("R4 trig_addr", int'(trig_addr), m_ta);
    chk("R7 last_page", int'(last_page), m_lp);
    chk("R7 page_full", int'(page_full), m_pf);
    if (mem_we) begin
      nwr++;
      last_wa = int'(mem_addr);
      writes_q.push_back(int'(mem_addr));
    end
    qual  = (((evt & trig_mask) != 0) || trig_mask[10]) ? 1 : 0;
    ts    = (cap_sel && mode == 2'd1) ? 1 : 0;
    tc    = (cap_sel && mode == 2'd2) ? 1 : 0;
    hit   = (m_run != 0 && cap_en && m_trg == 0 && (ts + tc) != 0 && qual != 0) ? 1 : 0;
    fin   = (m_trg != 0 && m_ctr != 0 && we != 0 && m_cnt == 1) ? 1 : 0;
    start = (cap_en && m_en == 0) ? 1 : 0;
    n_run = m_run; n_ptr = m_ptr; n_last = m_last; n_lp = m_lp; n_pf = m_pf;
    n_ts = m_ts; n_cs = m_cs; n_ta = m_ta; n_trg = m_trg; n_ctr = m_ctr; n_cnt = m_cnt;
    if (!cap_en) n_run = 0;
    else if (start != 0) n_run = 1;
    else if ((hit != 0 && ts != 0) || fin != 0) n_run = 0;
    if (start != 0) begin
      n_ptr = 0; n_last = 4095;
    end else if (we != 0) begin
      n_ptr = (m_ptr + 1) % 2048;
      n_last = addr;
      if (m_ptr % 128 == 127) n_lp = m_ptr / 128;
    end
    if (we != 0 && m_ptr == 2047) n_pf = 1;
    else if (flag_clr[2]) n_pf = 0;
    if (hit != 0) begin
      n_trg = 1; n_ctr = tc; n_cnt = 1024; n_ts = 1;
      n_ta = (we != 0) ? addr : m_last;
    end else begin
      if (m_trg != 0 && m_ctr != 0 && we != 0) n_cnt = m_cnt - 1;
      if (flag_clr[0]) n_ts = 0;
    end
    if ((hit != 0 && ts != 0) || fin != 0) n_cs = 1;
    else if (flag_clr[1]) n_cs = 0;
    if (start != 0) begin n_trg = 0; n_ctr = 0; end
    if (!cap_en) begin
      n_lp = 0; n_pf = 0; n_ts = 0; n_cs = 0; n_ta = 0; n_trg = 0; n_ctr = 0; n_cnt = 0;
    end
    @(posedge clk);
    m_en = cap_en ? 1 : 0; m_run = n_run; m_ptr = n_ptr; m_last = n_last; m_lp = n_lp;
    m_pf = n_pf; m_ts = n_ts; m_cs = n_cs; m_ta = n_ta; m_trg = n_trg; m_ctr = n_ctr;
    m_cnt = n_cnt;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    int ta, seen_at;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 mem_we", int'(mem_we), 0);
    chk("R10 trig_addr", int'(trig_addr), 0);
    chk("R10 flags", int'({trig_seen, cap_stopped, page_full}), 0);
    chk("R10 last_page", int'(last_page), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: free-running fill with events, triggers have no effect
    cap_sel = 1'b0; mode = 2'd1; trig_mask = 11'h7FF; cap_en = 1'b1;
    for (int i = 0; i < 2100; i++) begin
      smp_valid = 1'b1; smp_data = 32'hA500_0000 + i;
      evt = (i % 97 == 5) ? 11'h002 : 11'h000;
      tick();
    end
    evt = '0; smp_valid = 1'b0;
    chk("R2 no trigger when select is 0", int'(trig_seen), 0);
    chk("R7 page_full after wrap", int'(page_full), 1);
    chk("R1 wrapped write address", last_wa, 12'h800 + ((2099 - 1) % 2048));

    // R9: write-one-to-clear of page_full
    flag_clr = 3'b100; tick(); flag_clr = '0;
    chk("R9 page_full cleared", int'(page_full), 0);

    // R6: disable clears state and blocks writes
    cap_en = 1'b0; smp_valid = 1'b1; nwr = 0;
    idle(3);
    chk("R6 no writes while disabled", nwr, 0);
    chk("R6 last_page cleared", int'(last_page), 0);

    // R3, R4: stop mode, masked events ignored, swell triggers
    cap_sel = 1'b1; mode = 2'd1; trig_mask = 11'h002; cap_en = 1'b1; nwr = 0;
    for (int i = 0; i < 300; i++) begin
      smp_valid = (i % 3 != 2); smp_data = 32'h5500_0000 + i;
      evt = (i % 40 == 7) ? 11'h001 : 11'h000;
      tick();
    end
    chk("R3 masked event ignored", int'(trig_seen), 0);
    smp_valid = 1'b1; evt = 11'h002; ta = 12'h800 + (nwr % 2048);
    tick();
    evt = '0; nwr = 0;
    chk("R4 trig_addr is hit-cycle write", int'(trig_addr), ta);
    chk("R4 stopped flag", int'(cap_stopped), 1);
    idle(40);
    chk("R4 no writes after stop", nwr, 0);
    evt = 11'h002; tick(); evt = '0;
    chk("R3 later event ignored", int'(trig_addr), ta);

    // R9: clear trig_seen only
    flag_clr = 3'b001; tick(); flag_clr = '0;
    chk("R9 trig_seen cleared", int'(trig_seen), 0);
    chk("R9 cap_stopped kept", int'(cap_stopped), 1);

    // R8: still enabled after stop -> no restart
    idle(5);
    chk("R8 no restart without toggle", nwr, 0);

    // R5: centre mode, trigger late in ring with gapped strobes
    cap_en = 1'b0; idle(2);
    mode = 2'd2; trig_mask = 11'h020; cap_en = 1'b1; nwr = 0;
    for (int i = 0; i < 1500; i++) begin
      smp_valid = (i % 5 != 3); smp_data = 32'hC000_0000 + i; tick();
    end
    smp_valid = 1'b0; evt = 11'h020; ta = 12'h800 + ((nwr - 1) % 2048);
    tick();
    evt = '0;
    chk("R5 trig_seen at trigger", int'(trig_seen), 1);
    chk("R4 trig_addr with no hit write", int'(trig_addr), ta);
    nwr = 0; seen_at = 0;
    for (int i = 0; i < 1400; i++) begin
      smp_valid = (i % 4 != 1); smp_data = 32'hD000_0000 + i; tick();
      if (cap_stopped && seen_at == 0) seen_at = 1;
    end
    chk("R5 post-trigger write count", nwr, 1024);
    chk("R5 final address", last_wa, 12'h800 + ((ta - 12'h800 + 1024) % 2048));
    chk("R5 stopped", int'(cap_stopped), 1);

    // R8: force bit kept across re-enable triggers at once
    trig_mask = 11'h400; mode = 2'd1;
    cap_en = 1'b0; idle(2);
    cap_en = 1'b1; smp_valid = 1'b1; nwr = 0;
    idle(2);
    chk("R8 forced trigger address", int'(trig_addr), 12'h800);
    chk("R8 single write before stop", nwr, 1);
    idle(5);
    chk("R8 stays stopped", nwr, 1);

    // R6: disable clears flags and address
    cap_en = 1'b0; idle(2);
    chk("R6 trig_addr cleared", int'(trig_addr), 0);
    chk("R6 flags cleared", int'({trig_seen, cap_stopped, page_full}), 0);

    summary();
  end
endmodule